// File: doc/BRIEF.md
# Dual-Register Logic Macrocell

This block is one output cell of a programmable logic fabric. It receives twelve product terms from an AND plane and forms three sum terms from them. It also receives a clock term, a clear term and an output-enable term of its own, plus a static configuration word. It holds two state bits. Either bit can load its sum term or toggle on it. Each bit advances on a rising edge of its own chosen clock source and can be cleared by its own clear term. The cell drives an I/O pin value with its enable. It also returns two feedback lines to the array.

Clock sources are sampled on the fabric clock `clk`. A register advances on the `clk` edge where its selected source (the shared pin clock or its own clock term) is seen high after being low on the previous edge. A preload strobe can force both bits to known values. A lock bit blocks that strobe and blanks the observation port of the second bit. A legacy bit reduces the cell to load-only registers clocked by their product terms, with no direct feedback path.

Top module: `mc_macrocell`

## Requirements
- R1: With the merge bit (cfg_i[5]) clear, sum A is the OR of pt_i[3:0], sum B the OR of pt_i[7:4] and sum C the OR of pt_i[11:8]. When cfg_i[4] is set, pin_o shows sum C combinationally; when it is clear, pin_o shows register 1.
- R2: With cfg_i[5] set, the OR of all twelve product terms replaces sum A as register 1's input and replaces sum C on the combinational pin path. Register 2 still takes sum B.
- R3: A register in load mode (its mode bit cfg_i[0] or cfg_i[1] clear) takes its input sum on a fire edge and holds its value on all other edges.
- R4: A register in toggle mode (mode bit set) inverts its value on a fire edge when its input sum is 1, and holds it when the sum is 0.
- R5: With its select bit (cfg_i[2] for register 1, cfg_i[3] for register 2) set, a register fires on a rising edge of pin_clk_i. With the select bit clear, it fires on a rising edge of its own clock term clk_pt_i[n]. Edges of the other source have no effect.
- R6: rst_pt_i[n] clears register n to 0 at once, without waiting for a clock edge, and overrides preload and clocking. rst_n low clears both registers and the edge history.
- R7: On a clk edge with preload_i high and the lock bit clear, register 1 loads preload_d_i[0] and register 2 loads preload_d_i[1], ahead of any fire edge.
- R8: With the lock bit (cfg_i[7]) set, preload_i has no effect and obs_q2_o reads 0. With the lock bit clear, obs_q2_o shows register 2.
- R9: fb_o[0] is register 1. fb_o[1] is register 2, or sum B combinationally when the bypass bit (cfg_i[6]) is set.
- R10: pin_oe_o follows oe_pt_i.
- R11: With the legacy bit (cfg_i[8]) set, toggle mode, pin clock select and bypass are all forced off, whatever their bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples every clock source |
| rst_n | input | 1 | Active-low asynchronous reset |
| pt_i | input | 12 | Product terms: A in [3:0], B in [7:4], C in [11:8] |
| clk_pt_i | input | 2 | Clock term for register 1 (bit 0) and register 2 (bit 1) |
| rst_pt_i | input | 2 | Clear term for each register |
| oe_pt_i | input | 1 | Output-enable product term |
| pin_clk_i | input | 1 | Shared dedicated clock pin |
| preload_i | input | 1 | Preload strobe |
| preload_d_i | input | 2 | Preload values for register 1 (bit 0) and register 2 (bit 1) |
| cfg_i | input | 9 | Static configuration word; bit fields are given in the requirements |
| pin_o | output | 1 | Pin output value |
| pin_oe_o | output | 1 | Pin output enable |
| fb_o | output | 2 | Feedback lines to the array |
| obs_q2_o | output | 1 | Observation port for register 2 |

## Verification
A wrong stored bit in register 1 shows on fb_o[0] one cycle after the faulty edge, and also on pin_o when the registered path is selected. A wrong stored bit in register 2 shows on obs_q2_o in the same way, but only while the lock bit is clear, so long locked stretches can hide it. A stale edge-history bit causes an extra fire or a missed fire. That error appears one cycle later as a load or toggle that should not happen. The clear term acts within the same cycle, before the next clock edge.

// File: rtl/mc_pkg.sv
package mc_pkg;

   // Configuration word, LSB first: t_mode1 is bit 0, legacy is bit 8.
   typedef struct packed {
      logic legacy;     // [8] forces load mode, term clocking, no bypass
      logic lock;       // [7] blocks preload and hides register 2
      logic bypass2;    // [6] feedback 2 taken from sum B directly
      logic merge;      // [5] OR all product terms into one sum
      logic comb_out;   // [4] pin shows sum C instead of register 1
      logic pin_clk2;   // [3]
      logic pin_clk1;   // [2]
      logic t_mode2;    // [1]
      logic t_mode1;    // [0]
   } mc_cfg_t;

   localparam int CFG_W = $bits(mc_cfg_t);

endpackage

// File: rtl/mc_sum_bank.sv
module mc_sum_bank #(
   parameter int TERMS = 4,
   parameter int SUMS  = 3
) (
   input  logic [SUMS*TERMS-1:0] pt_i,
   output logic [SUMS-1:0]       sum_o,
   output logic                  all_o
);

   for (genvar g = 0; g < SUMS; g++) begin : g_sum
      assign sum_o[g] = |pt_i[g*TERMS +: TERMS];
   end

   assign all_o = |pt_i;

endmodule

// File: rtl/mc_edge_pick.sv
module mc_edge_pick (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_clk_i,
   input  logic pt_clk_i,
   input  logic use_pin_i,
   output logic fire_o
);

   logic pin_q;
   logic pt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
         pt_q  <= 1'b0;
      end else begin
         pin_q <= pin_clk_i;
         pt_q  <= pt_clk_i;
      end
   end

   // R5: only the selected source can produce a fire edge
   assign fire_o = use_pin_i ? (pin_clk_i & ~pin_q) : (pt_clk_i & ~pt_q);

endmodule

// File: rtl/mc_flop.sv
module mc_flop (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic fire_i,
   input  logic t_mode_i,
   input  logic din_i,
   input  logic pl_en_i,
   input  logic pl_d_i,
   output logic q_o
);

   logic clr_a;
   assign clr_a = ~rst_n | clr_i;

   // R6 clear first, R7 preload next, then R3/R4 on a fire edge
   always_ff @(posedge clk or posedge clr_a) begin
      if (clr_a)
         q_o <= 1'b0;
      else if (pl_en_i)
         q_o <= pl_d_i;
      else if (fire_i)
         q_o <= t_mode_i ? (q_o ^ din_i) : din_i;
   end

endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell #(
   parameter int TERMS_PER_SUM = 4,
   parameter int N_SUMS        = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [N_SUMS*TERMS_PER_SUM-1:0]   pt_i,
   input  logic [1:0]                        clk_pt_i,
   input  logic [1:0]                        rst_pt_i,
   input  logic                              oe_pt_i,
   input  logic                              pin_clk_i,
   input  logic                              preload_i,
   input  logic [1:0]                        preload_d_i,
   input  logic [mc_pkg::CFG_W-1:0]          cfg_i,
   output logic                              pin_o,
   output logic                              pin_oe_o,
   output logic [1:0]                        fb_o,
   output logic                              obs_q2_o
);
   import mc_pkg::*;

   localparam int N_REGS = 2;
   localparam int SUM_A  = 0;
   localparam int SUM_B  = 1;
   localparam int SUM_C  = 2;

   if (N_SUMS != 3) begin : g_bad_sums
      $error("mc_macrocell: N_SUMS must be 3");
   end
   if (TERMS_PER_SUM < 1) begin : g_bad_terms
      $error("mc_macrocell: TERMS_PER_SUM must be at least 1");
   end

   mc_cfg_t cfg;
   assign cfg = mc_cfg_t'(cfg_i);

   logic [N_SUMS-1:0] sums;
   logic              all_terms;

   mc_sum_bank #(
      .TERMS (TERMS_PER_SUM),
      .SUMS  (N_SUMS)
   ) u_sums (
      .pt_i  (pt_i),
      .sum_o (sums),
      .all_o (all_terms)
   );

   // R2: merged sum feeds register 1 and the combinational pin path
   logic [N_REGS-1:0] din;
   logic              comb_val;
   assign din[0]   = cfg.merge ? all_terms : sums[SUM_A];
   assign din[1]   = sums[SUM_B];
   assign comb_val = cfg.merge ? all_terms : sums[SUM_C];

   // R11: legacy mode strips toggle, pin clocking and bypass
   logic [N_REGS-1:0] t_eff;
   logic [N_REGS-1:0] pin_eff;
   logic              bypass_eff;
   logic              pl_ok;
   assign t_eff      = {cfg.t_mode2, cfg.t_mode1} & {N_REGS{~cfg.legacy}};
   assign pin_eff    = {cfg.pin_clk2, cfg.pin_clk1} & {N_REGS{~cfg.legacy}};
   assign bypass_eff = cfg.bypass2 & ~cfg.legacy;
   assign pl_ok      = preload_i & ~cfg.lock;   // R8

   logic [N_REGS-1:0] fire;
   logic [N_REGS-1:0] q;

   for (genvar r = 0; r < N_REGS; r++) begin : g_reg
      mc_edge_pick u_edge (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_clk_i (pin_clk_i),
         .pt_clk_i  (clk_pt_i[r]),
         .use_pin_i (pin_eff[r]),
         .fire_o    (fire[r])
      );

      mc_flop u_flop (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr_i    (rst_pt_i[r]),
         .fire_i   (fire[r]),
         .t_mode_i (t_eff[r]),
         .din_i    (din[r]),
         .pl_en_i  (pl_ok),
         .pl_d_i   (preload_d_i[r]),
         .q_o      (q[r])
      );
   end

   assign pin_o    = cfg.comb_out ? comb_val : q[0];   // R1
   assign pin_oe_o = oe_pt_i;                          // R10
   assign fb_o[0]  = q[0];                             // R9
   assign fb_o[1]  = bypass_eff ? din[1] : q[1];
   assign obs_q2_o = cfg.lock ? 1'b0 : q[1];

endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk #(
   parameter int TERMS = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3*TERMS-1:0] pt_i,
   input logic [1:0]       rst_pt_i,
   input logic             pin_clk_i,
   input logic             preload_i,
   input logic             pl_d0,
   input logic             t_mode1,
   input logic             pin_clk1,
   input logic             merge,
   input logic             bypass2,
   input logic             lock,
   input logic             legacy,
   input logic [1:0]       fb_o,
   input logic             obs_q2_o
);

   logic pin_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_seen <= 1'b0;
      else        pin_seen <= pin_clk_i;
   end

   logic in1;
   assign in1 = merge ? (|pt_i) : (|pt_i[TERMS-1:0]);

   AST_CLEAR_REG1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pt_i[0] |-> !fb_o[0]);                                       // R6
   AST_CLEAR_REG2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_pt_i[1] && !(bypass2 && !legacy)) |-> !fb_o[1]);             // R6
   AST_LOCK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
      lock |-> !obs_q2_o);                                             // R8
   AST_BYPASS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass2 && !legacy) |-> (fb_o[1] == (|pt_i[2*TERMS-1:TERMS]))); // R9
   AST_PRELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (preload_i && !lock && !rst_pt_i[0])
      |=> (rst_pt_i[0] || (fb_o[0] == $past(pl_d0))));                 // R7
   AST_TOGGLE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (t_mode1 && pin_clk1 && !legacy && in1 && pin_clk_i && !pin_seen
       && !(preload_i && !lock) && !rst_pt_i[0])
      |=> (rst_pt_i[0] || (fb_o[0] == !$past(fb_o[0]))));              // R4

endmodule

bind mc_macrocell mc_macrocell_chk #(
   .TERMS (TERMS_PER_SUM)
) chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pt_i      (pt_i),
   .rst_pt_i  (rst_pt_i),
   .pin_clk_i (pin_clk_i),
   .preload_i (preload_i),
   .pl_d0     (preload_d_i[0]),
   .t_mode1   (cfg_i[0]),
   .pin_clk1  (cfg_i[2]),
   .merge     (cfg_i[5]),
   .bypass2   (cfg_i[6]),
   .lock      (cfg_i[7]),
   .legacy    (cfg_i[8]),
   .fb_o      (fb_o),
   .obs_q2_o  (obs_q2_o)
);

// File: tb/mc_macrocell_test.sv
`timescale 1ns/1ps
module mc_macrocell_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] pt = '0;
   logic [1:0]  cpt = '0;
   logic [1:0]  rpt = '0;
   logic        oe = 1'b0;
   logic        pclk = 1'b0;
   logic        pl = 1'b0;
   logic [1:0]  pld = '0;
   logic [8:0]  cfg = '0;

   logic        pin_o, pin_oe_o, obs_q2_o;
   logic [1:0]  fb_o;

   int n_chk = 0;
   int n_fail = 0;

   logic [1:0] mq = '0;
   logic       m_pin_prev = 1'b0;
   logic [1:0] m_pt_prev = '0;

   always #10 clk = ~clk;   // 50 MHz

   mc_macrocell uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .pt_i        (pt),
      .clk_pt_i    (cpt),
      .rst_pt_i    (rpt),
      .oe_pt_i     (oe),
      .pin_clk_i   (pclk),
      .preload_i   (pl),
      .preload_d_i (pld),
      .cfg_i       (cfg),
      .pin_o       (pin_o),
      .pin_oe_o    (pin_oe_o),
      .fb_o        (fb_o),
      .obs_q2_o    (obs_q2_o)
   );

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   function automatic logic din1_of(input logic [11:0] p, input logic [8:0] c);
      return c[5] ? (|p) : (|p[3:0]);
   endfunction

   // Called at a falling edge with inputs already driven; returns at the next falling edge.
   task automatic step(input string tag);
      logic sb, sc, comb, legacy;
      logic [1:0] din, t_eff, pin_eff, fire;
      #1;
      if (rpt[0]) mq[0] = 1'b0;   // R6 immediate clear
      if (rpt[1]) mq[1] = 1'b0;
      legacy  = cfg[8];
      sb      = |pt[7:4];
      sc      = |pt[11:8];
      din     = {sb, din1_of(pt, cfg)};
      comb    = cfg[5] ? (|pt) : sc;
      t_eff   = cfg[1:0] & {2{~legacy}};
      pin_eff = cfg[3:2] & {2{~legacy}};
      chk(tag, "pin_o", pin_o, cfg[4] ? comb : mq[0]);
      chk(tag, "pin_oe_o", pin_oe_o, oe);
      chk(tag, "fb_o[0]", fb_o[0], mq[0]);
      chk(tag, "fb_o[1]", fb_o[1], (cfg[6] && !legacy) ? sb : mq[1]);
      chk(tag, "obs_q2_o", obs_q2_o, cfg[7] ? 1'b0 : mq[1]);
      for (int r = 0; r < 2; r++) begin
         fire[r] = pin_eff[r] ? (pclk & ~m_pin_prev) : (cpt[r] & ~m_pt_prev[r]);
         if (rpt[r])            mq[r] = 1'b0;
         else if (pl && !cfg[7]) mq[r] = pld[r];
         else if (fire[r])      mq[r] = t_eff[r] ? (mq[r] ^ din[r]) : din[r];
      end
      m_pin_prev = pclk;
      m_pt_prev  = cpt;
      @(negedge clk);
   endtask

   task automatic idle();
      pt = '0; cpt = '0; rpt = '0; oe = 1'b0; pclk = 1'b0; pl = 1'b0; pld = '0;
   endtask

   initial begin
      #(64'd200000 * 20);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h1d5a_77c3));
      // R6: reset state
      repeat (2) @(negedge clk);
      #1;
      chk("R6", "fb_o reset", fb_o[0] | fb_o[1], 1'b0);
      chk("R6", "obs reset", obs_q2_o, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      idle(); step("R6");

      // R10
      oe = 1'b1; step("R10"); oe = 1'b0; step("R10");
      // R1: combinational path from sum C only
      cfg = 9'h010; pt = 12'h100; step("R1"); pt = 12'h001; step("R1");
      // R2: merged sum reaches the pin from group B
      cfg = 9'h030; pt = 12'h010; step("R2"); pt = 12'h000; step("R2");
      // R3: load on term clock edge, hold otherwise
      cfg = 9'h000; pt = 12'h001; cpt = 2'b01; step("R3");
      cpt = 2'b00; step("R3"); pt = 12'h000; step("R3");
      cpt = 2'b01; step("R3"); cpt = 2'b00; step("R3");
      // R4: toggle
      cfg = 9'h001; pt = 12'h001;
      for (int k = 0; k < 4; k++) begin cpt = 2'b01; step("R4"); cpt = 2'b00; step("R4"); end
      pt = 12'h000; cpt = 2'b01; step("R4"); cpt = 2'b00; step("R4");
      // R5: pin clock selected, term clock ignored
      cfg = 9'h004; pt = 12'h001; cpt = 2'b01; step("R5"); cpt = 2'b00; step("R5");
      pclk = 1'b1; step("R5"); pclk = 1'b0; step("R5");
      // R7: preload both
      cfg = 9'h000; pl = 1'b1; pld = 2'b11; step("R7"); pl = 1'b0; step("R7");
      pl = 1'b1; pld = 2'b10; step("R7"); pl = 1'b0; step("R7");
      // R6: clear beats preload
      pl = 1'b1; pld = 2'b11; rpt = 2'b01; step("R6"); pl = 1'b0; step("R6"); rpt = 2'b00; step("R6");
      // R8: lock blocks preload and hides register 2
      pl = 1'b1; pld = 2'b11; step("R8"); pl = 1'b0; cfg = 9'h080;
      step("R8"); pl = 1'b1; pld = 2'b00; step("R8"); pl = 1'b0; step("R8");
      cfg = 9'h000; step("R8");
      // R9: bypass feedback
      cfg = 9'h040; pt = 12'h020; step("R9"); pt = 12'h000; step("R9");
      // R11: legacy strips toggle, pin clock and bypass
      cfg = 9'h1C5; pt = 12'h021;
      cpt = 2'b11; step("R11"); cpt = 2'b00; step("R11");
      cpt = 2'b11; step("R11"); cpt = 2'b00; step("R11");
      pt = 12'h000; pclk = 1'b1; step("R11"); pclk = 1'b0; step("R11");
      idle();

      // Random phase
      for (int n = 0; n < 4000; n++) begin
         if (n % 16 == 0) cfg = 9'($urandom());
         pt   = 12'($urandom() & $urandom() & $urandom());
         cpt  = 2'($urandom());
         pclk = 1'($urandom());
         oe   = 1'($urandom());
         rpt  = (($urandom() & 15) == 0) ? 2'($urandom()) : 2'b00;
         pl   = (($urandom() & 7) == 0);
         pld  = 2'($urandom());
         step("R3");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule